// File: doc/BRIEF.md
# Network Media Port Auto-Selector

This block decides which of three network media ports drives the line: an external PHY port (media-independent), a twisted-pair port, or an attachment-unit (AUI) port. In automatic mode the choice follows a fixed priority. A PHY that reports itself present wins. Next comes twisted-pair, when its link is passing or link testing is disabled. AUI is the fallback. In manual mode the choice comes from a two-bit port-select field. The block drives one enable per port, a gate for link-integrity pulses on the twisted-pair port, and two sleep-mode strobes.

A small configuration register holds three bits: automatic select, light-sleep choice, and an enable for the external address-detection interface. A hard reset sets these bits. A soft reset and a stop command leave them alone. A soft reset or a stop does, however, abort any transmission in progress, so a port change that was waiting on that transmission takes effect at once. The PHY-present and link-pass inputs arrive from other clock domains and pass through a two-flop synchronizer.

The selection core is a three-state machine whose states are the ports themselves: `ST_AUI` (00), `ST_TP` (01) and `ST_MII` (11). From any state the machine takes `T_SWITCH` to the target port when the target differs from the current state and the switch gate is open. The gate is open when no transmission is active, or when a soft reset or stop is present. Otherwise it takes `T_HOLD` and stays where it is.

Top module: `media_port_sel`

## Requirements
- R1: Exactly one of `mii_en`, `tp_en`, `aui_en` is high at all times, and `act_port` encodes the active port as 00 = AUI, 01 = twisted-pair, 11 = PHY port.
- R2: With automatic select on (config bit 0 = 1), the target is the PHY port when PHY is present. Otherwise it is twisted-pair when the link passes or `link_test_dis` is 1. Otherwise it is AUI.
- R3: With automatic select off, `man_port_sel` picks the port: 01 gives twisted-pair, 11 gives the PHY port, and 00 or 10 gives AUI. PHY-present and link state are then ignored.
- R4: While `tx_active` is 1 (and neither `soft_rst` nor `stop_cmd` is high), `act_port` does not change. A pending change is applied on the first rising edge at which `tx_active` is 0.
- R5: A cycle with `soft_rst` or `stop_cmd` high applies a pending change on that edge even while `tx_active` is 1.
- R6: `lip_en` is 1 when automatic select is on and PHY is not present, whatever the link state. With automatic select off, it is 1 only when `man_port_sel` is 01. Otherwise it is 0.
- R7: With `sleep_req` high and twisted-pair active, `sleep_light` is driven when config bit 1 is 1 and `sleep_deep` when it is 0. With another port active, both are 0.
- R8: Hard reset gives `cfg_rdata` = 8'h01 (automatic select on, other bits 0) and the AUI port.
- R9: `soft_rst` and `stop_cmd` never change the configuration bits, and a write in the same cycle still lands. Bits 7..3 read as 0, and writes to them have no effect.
- R10: A change on `phy_present_a` or `tp_link_pass_a` reaches `act_port` on the third rising edge after it, and not on the second.
- R11: `ext_addr_en` equals config bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset pulse; aborts transmission, keeps config |
| stop_cmd | input | 1 | Stop command pulse; aborts transmission, keeps config |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| man_port_sel | input | 2 | Manual port-select field |
| link_test_dis | input | 1 | Link test disabled; treat twisted-pair as passing |
| phy_present_a | input | 1 | PHY present (asynchronous) |
| tp_link_pass_a | input | 1 | Twisted-pair link pass (asynchronous) |
| tx_active | input | 1 | A frame is being transmitted |
| sleep_req | input | 1 | Sleep request |
| act_port | output | 2 | Active port code |
| mii_en | output | 1 | PHY port enable |
| tp_en | output | 1 | Twisted-pair port enable |
| aui_en | output | 1 | AUI port enable |
| lip_en | output | 1 | Link-integrity pulse enable |
| sleep_light | output | 1 | Light sleep strobe |
| sleep_deep | output | 1 | Deep sleep strobe |
| ext_addr_en | output | 1 | External address interface enable |

## Verification
Two functions can fall in the same cycle: the transmit hold that freezes the port, and a soft reset or stop that aborts the transmission. The bench parks a port change behind a raised `tx_active`, then pulses `stop_cmd` and later `soft_rst` while `tx_active` stays high, and expects the new port on that very edge. It also issues a configuration write in the same cycle as `soft_rst` and expects the written value to survive.

// File: rtl/mps_pkg.sv
package mps_pkg;
    localparam int CFG_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int BIT_AUTO    = 0;
    localparam int BIT_LIGHT   = 1;
    localparam int BIT_EXTADDR = 2;
    localparam int CFG_USED    = 3;
    localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(1) << BIT_AUTO;

    // State codes double as the active-port status encoding
    typedef enum logic [1:0] {
        ST_AUI = 2'b00,
        ST_TP  = 2'b01,
        ST_MII = 2'b11
    } port_st_e;
endpackage

// File: rtl/mps_sync.sv
module mps_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/mps_cfg_reg.sv
module mps_cfg_reg
    import mps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic             auto_sel,
    output logic             light_sleep,
    output logic             ext_addr
);
    logic [CFG_USED-1:0] bits_q;

    // Only hard reset touches these bits; soft reset and stop are not wired here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bits_q <= CFG_RST[CFG_USED-1:0];
        else if (wr_en) bits_q <= wdata[CFG_USED-1:0];
    end

    always_comb begin
        rdata = '0;
        rdata[CFG_USED-1:0] = bits_q;
    end

    assign auto_sel    = bits_q[BIT_AUTO];
    assign light_sleep = bits_q[BIT_LIGHT];
    assign ext_addr    = bits_q[BIT_EXTADDR];
endmodule

// File: rtl/mps_port_fsm.sv
module mps_port_fsm
    import mps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_sel,
    input  logic       phy_s,
    input  logic       tp_s,
    input  logic       link_test_dis,
    input  logic [1:0] man_sel,
    input  logic       tx_active,
    input  logic       force_apply,
    input  logic       light_sleep,
    input  logic       sleep_req,
    output logic [1:0] act_port,
    output logic       mii_en,
    output logic       tp_en,
    output logic       aui_en,
    output logic       lip_en,
    output logic       sleep_light,
    output logic       sleep_deep
);
    port_st_e state_q, state_d, target;
    logic     gate_open;

    always_comb begin
        if (auto_sel) begin
            if (phy_s)                      target = ST_MII;
            else if (tp_s || link_test_dis) target = ST_TP;
            else                            target = ST_AUI;
        end else begin
            unique case (man_sel)
                2'b01:   target = ST_TP;
                2'b11:   target = ST_MII;
                default: target = ST_AUI;
            endcase
        end
    end

    assign gate_open = !tx_active || force_apply;

    // Transitions: T_SWITCH to target when gate open, else T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AUI, ST_TP, ST_MII: begin
                if (target != state_q && gate_open) state_d = target;
            end
            default: state_d = ST_AUI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AUI;
        else        state_q <= state_d;
    end

    always_comb begin
        act_port    = state_q;
        mii_en      = 1'b0;
        tp_en       = 1'b0;
        aui_en      = 1'b0;
        sleep_light = 1'b0;
        sleep_deep  = 1'b0;
        unique case (state_q)
            ST_MII: mii_en = 1'b1;
            ST_TP: begin
                tp_en       = 1'b1;
                sleep_light = sleep_req && light_sleep;
                sleep_deep  = sleep_req && !light_sleep;
            end
            default: aui_en = 1'b1;
        endcase
        lip_en = auto_sel ? !phy_s : (man_sel == 2'b01);
    end
endmodule

// File: rtl/media_port_sel.sv
module media_port_sel
    import mps_pkg::*;
(
    input  logic             clk,
    input  logic             hard_rst_n,
    input  logic             soft_rst,
    input  logic             stop_cmd,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [1:0]       man_port_sel,
    input  logic             link_test_dis,
    input  logic             phy_present_a,
    input  logic             tp_link_pass_a,
    input  logic             tx_active,
    input  logic             sleep_req,
    output logic [1:0]       act_port,
    output logic             mii_en,
    output logic             tp_en,
    output logic             aui_en,
    output logic             lip_en,
    output logic             sleep_light,
    output logic             sleep_deep,
    output logic             ext_addr_en
);
    logic [1:0] sync_q;
    logic       auto_sel, light_sleep;

    mps_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (hard_rst_n),
        .d_async ({phy_present_a, tp_link_pass_a}),
        .q_sync  (sync_q)
    );

    mps_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (hard_rst_n),
        .wr_en       (cfg_wr_en),
        .wdata       (cfg_wdata),
        .rdata       (cfg_rdata),
        .auto_sel    (auto_sel),
        .light_sleep (light_sleep),
        .ext_addr    (ext_addr_en)
    );

    mps_port_fsm u_fsm (
        .clk           (clk),
        .rst_n         (hard_rst_n),
        .auto_sel      (auto_sel),
        .phy_s         (sync_q[1]),
        .tp_s          (sync_q[0]),
        .link_test_dis (link_test_dis),
        .man_sel       (man_port_sel),
        .tx_active     (tx_active),
        .force_apply   (soft_rst || stop_cmd),
        .light_sleep   (light_sleep),
        .sleep_req     (sleep_req),
        .act_port      (act_port),
        .mii_en        (mii_en),
        .tp_en         (tp_en),
        .aui_en        (aui_en),
        .lip_en        (lip_en),
        .sleep_light   (sleep_light),
        .sleep_deep    (sleep_deep)
    );
endmodule

// File: rtl/mps_chk.sv
module mps_chk (
    input logic       clk,
    input logic       hard_rst_n,
    input logic       soft_rst,
    input logic       stop_cmd,
    input logic       cfg_wr_en,
    input logic [7:0] cfg_rdata,
    input logic [1:0] man_port_sel,
    input logic       tx_active,
    input logic [1:0] act_port,
    input logic       mii_en,
    input logic       tp_en,
    input logic       aui_en,
    input logic       lip_en,
    input logic       sleep_light,
    input logic       sleep_deep
);
    a_r1_one_enable: assert property (@(posedge clk) disable iff (!hard_rst_n)
        $countones({mii_en, tp_en, aui_en}) == 1);

    a_r1_code_legal: assert property (@(posedge clk) disable iff (!hard_rst_n)
        act_port != 2'b10);

    a_r4_tx_hold: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (tx_active && !soft_rst && !stop_cmd) |=> act_port == $past(act_port));

    a_r6_manual_lip: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !cfg_rdata[0] |-> lip_en == (man_port_sel == 2'b01));

    a_r7_sleep_tp_only: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (sleep_light || sleep_deep) |-> (tp_en && !(sleep_light && sleep_deep)));

    a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!hard_rst_n)
        cfg_rdata[7:3] == 5'd0);

    a_r9_soft_keeps_cfg: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ((soft_rst || stop_cmd) && !cfg_wr_en) |=> $stable(cfg_rdata));
endmodule

bind media_port_sel mps_chk u_chk (
    .clk          (clk),
    .hard_rst_n   (hard_rst_n),
    .soft_rst     (soft_rst),
    .stop_cmd     (stop_cmd),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_rdata    (cfg_rdata),
    .man_port_sel (man_port_sel),
    .tx_active    (tx_active),
    .act_port     (act_port),
    .mii_en       (mii_en),
    .tp_en        (tp_en),
    .aui_en       (aui_en),
    .lip_en       (lip_en),
    .sleep_light  (sleep_light),
    .sleep_deep   (sleep_deep)
);

// File: tb/media_port_sel_tb.sv
module media_port_sel_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       hard_rst_n, soft_rst, stop_cmd, cfg_wr_en;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic [1:0] man_port_sel, act_port;
    logic       link_test_dis, phy_present_a, tp_link_pass_a, tx_active, sleep_req;
    logic       mii_en, tp_en, aui_en, lip_en, sleep_light, sleep_deep, ext_addr_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    media_port_sel u_dut (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .man_port_sel(man_port_sel), .link_test_dis(link_test_dis),
        .phy_present_a(phy_present_a), .tp_link_pass_a(tp_link_pass_a),
        .tx_active(tx_active), .sleep_req(sleep_req), .act_port(act_port),
        .mii_en(mii_en), .tp_en(tp_en), .aui_en(aui_en), .lip_en(lip_en),
        .sleep_light(sleep_light), .sleep_deep(sleep_deep), .ext_addr_en(ext_addr_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_wdata = v; cfg_wr_en = 1'b1;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    function automatic logic [1:0] exp_port(input logic au, input logic ph, input logic tp,
                                            input logic ltd, input logic [1:0] man);
        if (au) return ph ? 2'b11 : ((tp || ltd) ? 2'b01 : 2'b00);
        return (man == 2'b01) ? 2'b01 : ((man == 2'b11) ? 2'b11 : 2'b00);
    endfunction

    function automatic logic [7:0] exp_en(input logic [1:0] p);
        return {5'd0, p == 2'b11, p == 2'b01, p == 2'b00};
    endfunction

    task automatic check_port(input string req, input logic [1:0] p);
        chk(req, {6'd0, act_port}, {6'd0, p});
        chk("R1", {5'd0, mii_en, tp_en, aui_en}, exp_en(p));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        hard_rst_n = 1'b0; soft_rst = 1'b0; stop_cmd = 1'b0; cfg_wr_en = 1'b0;
        cfg_wdata = 8'h00; man_port_sel = 2'b00; link_test_dis = 1'b0;
        phy_present_a = 1'b0; tp_link_pass_a = 1'b0; tx_active = 1'b0; sleep_req = 1'b0;
        tick(3);
        hard_rst_n = 1'b1;
        tick(1);
        // R8 reset state
        chk("R8", cfg_rdata, 8'h01);
        check_port("R8", 2'b00);
        chk("R6", {7'd0, lip_en}, 8'd1);

        // R2 / R6: automatic sweep
        for (int i = 0; i < 8; i++) begin
            phy_present_a = i[2]; tp_link_pass_a = i[1]; link_test_dis = i[0];
            tick(4);
            check_port("R2", exp_port(1'b1, i[2], i[1], i[0], 2'b00));
            chk("R6", {7'd0, lip_en}, {7'd0, !i[2]});
        end

        // R10: synchronizer latency
        phy_present_a = 1'b0; tp_link_pass_a = 1'b0; link_test_dis = 1'b0;
        tick(4);
        phy_present_a = 1'b1;
        tick(2);
        check_port("R10", 2'b00);
        tick(1);
        check_port("R10", 2'b11);

        // R3 / R6: manual sweep, PHY and link must be ignored
        cfg_write(8'h00);
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                man_port_sel = m[1:0]; phy_present_a = k[1]; tp_link_pass_a = k[0];
                tick(4);
                check_port("R3", exp_port(1'b0, k[1], k[0], 1'b0, m[1:0]));
                chk("R6", {7'd0, lip_en}, {7'd0, m == 1});
            end
        end

        // R4: hold during transmission
        man_port_sel = 2'b00; tick(2);
        tx_active = 1'b1;
        man_port_sel = 2'b01;
        tick(6);
        check_port("R4", 2'b00);
        tx_active = 1'b0;
        tick(1);
        check_port("R4", 2'b01);

        // R5: stop and soft reset apply a pending change during transmission
        tx_active = 1'b1;
        man_port_sel = 2'b11;
        tick(3);
        check_port("R4", 2'b01);
        stop_cmd = 1'b1;
        tick(1);
        stop_cmd = 1'b0;
        check_port("R5", 2'b11);
        chk("R9", cfg_rdata, 8'h00);
        man_port_sel = 2'b00;
        tick(3);
        check_port("R4", 2'b11);
        soft_rst = 1'b1;
        cfg_wdata = 8'h04; cfg_wr_en = 1'b1;
        tick(1);
        soft_rst = 1'b0; cfg_wr_en = 1'b0;
        check_port("R5", 2'b00);
        chk("R9", cfg_rdata, 8'h04);
        chk("R11", {7'd0, ext_addr_en}, 8'd1);
        tx_active = 1'b0;

        // R7: sleep mode decode
        sleep_req = 1'b1;
        tick(2);
        chk("R7", {6'd0, sleep_light, sleep_deep}, 8'd0);
        man_port_sel = 2'b01;
        cfg_write(8'h02);
        tick(2);
        chk("R7", {6'd0, sleep_light, sleep_deep}, 8'b10);
        cfg_write(8'h00);
        tick(1);
        chk("R7", {6'd0, sleep_light, sleep_deep}, 8'b01);
        sleep_req = 1'b0;
        tick(1);
        chk("R7", {6'd0, sleep_light, sleep_deep}, 8'd0);

        // R9 / R11: reserved bits
        cfg_write(8'hFF);
        chk("R9", cfg_rdata, 8'h07);
        chk("R11", {7'd0, ext_addr_en}, 8'd1);
        cfg_write(8'hF8);
        chk("R9", cfg_rdata, 8'h00);
        chk("R11", {7'd0, ext_addr_en}, 8'd0);

        // R8: hard reset restores defaults
        cfg_write(8'h06);
        man_port_sel = 2'b11; tick(3);
        hard_rst_n = 1'b0; tick(2);
        hard_rst_n = 1'b1; phy_present_a = 1'b0; tp_link_pass_a = 1'b0;
        tick(1);
        chk("R8", cfg_rdata, 8'h01);
        check_port("R8", 2'b00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule